// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer. It does not use one wide modulo counter. A small prescaler that divides by either 4 or 5 sits in front of two slower counters. The main counter counts prescaler cycles and sets the length of each output period. The swallow counter holds the prescaler at divide-by-5 for the first few prescaler cycles of every period, then releases it to divide-by-4. The ratio is N = 4·P + S, where P is the 5-bit main value and S is the 2-bit swallow value. The legal range of N is 16 to 127.

The block sits in the feedback path of a synthesizer loop. It emits one single-cycle pulse per N input cycles, and that pulse goes to the phase comparison stage. A new setting is taken only when a period closes, so retuning never produces a shortened or stretched period. An illegal setting raises a flag, and the divider keeps its last accepted ratio.

Top module: `pswallow_divider`

## Requirements
- R1: The number of input-clock rising edges from one output pulse to the next equals 4·P + S for the accepted setting, where P is `main_cnt_i` read as unsigned and S is `swal_cnt_i` read as unsigned.
- R2: `div_pulse_o` is high for exactly one input cycle per period, and it is low in the cycle after every pulse.
- R3: Within every period, the prescaler divides by 5 for the first S prescaler cycles and by 4 for the remaining P−S. Its modulus-control line changes only at a prescaler cycle boundary.
- R4: A setting is legal when P > S and 4·P + S ≥ 16. `bad_ratio_o` is 1 in the cycle after an illegal setting is present on the inputs and 0 in the cycle after a legal one.
- R5: An illegal setting is never taken. Periods keep the last accepted ratio until a legal setting is captured.
- R6: The inputs are captured only at the clock edge that ends a period, and that is the same edge that raises the output pulse. The period in progress finishes at the old ratio, including when the inputs change in its last input cycle. The next period uses the new ratio.
- R7: While `rst_n` is low, `div_pulse_o` is 0. The first pulse comes N rising edges after the first edge with `rst_n` high, where N comes from the inputs held during reset. If those inputs are illegal, N is 16 (P = 4, S = 0).
- R8: Both ends of the range work: P = 4, S = 0 gives 16, and P = 31, S = 3 gives 127.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| main_cnt_i | input | 5 | Main counter setting P |
| swal_cnt_i | input | 2 | Swallow counter setting S |
| div_pulse_o | output | 1 | One-cycle pulse per N input cycles |
| bad_ratio_o | output | 1 | Registered flag: the present setting is illegal |

## Verification
Two functions can fall on the same edge: the capture of a new setting and the reload that ends a period and raises the pulse. The bench provokes this in two ways. It changes the inputs in the final input cycle of a period, and it changes them at random offsets inside a period, with both legal and illegal values. The result is judged by two measured intervals. The interval that closes must still have the old length, and the one that follows must have the new length. When the new setting is illegal, the following interval must keep the old length.

// File: rtl/psd_pkg.sv
// Package: default geometry of the pulse-swallow divider and the prescaler
// modulus encoding. Assumes the swallow range is one below the low modulus.
package psd_pkg;
    localparam int unsigned PRE_LO = 4;     // low prescaler modulus; high is PRE_LO+1
    localparam int unsigned P_W    = 5;     // main counter setting width
    localparam int unsigned S_W    = 2;     // swallow setting width
    localparam int unsigned N_MIN  = 16;    // smallest supported ratio

    typedef enum logic {
        MOD_LO = 1'b0,                      // divide by PRE_LO
        MOD_HI = 1'b1                       // divide by PRE_LO+1
    } modsel_e;
endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: counts input cycles and gives a one-cycle tick at
// the last cycle of each prescaler period. The modulus is PRE_LO+1 when
// mod_i is MOD_HI. Assumes mod_i changes only in the cycle after a tick.
module psd_prescaler #(
    parameter int unsigned PRE_LO = psd_pkg::PRE_LO,
    parameter int unsigned PH_W   = $clog2(PRE_LO + 1)
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  psd_pkg::modsel_e mod_i,
    output logic             tick_o
);
    localparam logic [PH_W-1:0] LAST_LO = PH_W'(PRE_LO - 1);
    localparam logic [PH_W-1:0] LAST_HI = PH_W'(PRE_LO);

    logic [PH_W-1:0] ph_q;

    // Tick marks the final input cycle of the current prescaler period.
    assign tick_o = (ph_q == ((mod_i == psd_pkg::MOD_HI) ? LAST_HI : LAST_LO));

    // Phase counter: wraps at the end of each prescaler period.
    always_ff @(posedge clk_in) begin
        if (!rst_n || tick_o) ph_q <= '0;
        else                  ph_q <= ph_q + PH_W'(1);
    end
endmodule

// File: rtl/psd_ratio_check.sv
// Legality check of a requested setting: main value above swallow value and
// resulting ratio at least N_MIN. Purely combinational.
module psd_ratio_check #(
    parameter int unsigned PRE_LO = psd_pkg::PRE_LO,
    parameter int unsigned P_W    = psd_pkg::P_W,
    parameter int unsigned S_W    = psd_pkg::S_W,
    parameter int unsigned N_MIN  = psd_pkg::N_MIN
) (
    input  logic [P_W-1:0] p_i,
    input  logic [S_W-1:0] s_i,
    output logic           ok_o
);
    int unsigned p_val;
    int unsigned s_val;

    // Widen both fields and apply the two legality rules.
    always_comb begin
        p_val = int'(p_i);
        s_val = int'(s_i);
        ok_o  = (p_val > s_val) && ((p_val * PRE_LO + s_val) >= N_MIN);
    end
endmodule

// File: rtl/psd_counters.sv
// Main and swallow counters. Both step on prescaler ticks. The swallow
// counter holds the prescaler at the high modulus while it is non-zero.
// When the main counter runs out, both reload and a one-cycle pulse is
// registered. A legal request is captured only at that edge or in reset.
// Otherwise the last accepted ratio is reused, or a fallback ratio in reset.
module psd_counters #(
    parameter int unsigned PRE_LO = psd_pkg::PRE_LO,
    parameter int unsigned P_W    = psd_pkg::P_W,
    parameter int unsigned S_W    = psd_pkg::S_W,
    parameter int unsigned N_MIN  = psd_pkg::N_MIN
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [P_W-1:0]   req_p_i,
    input  logic [S_W-1:0]   req_s_i,
    input  logic             req_ok_i,
    output psd_pkg::modsel_e mod_o,
    output logic             pulse_o
);
    localparam logic [P_W-1:0] FB_P = P_W'((N_MIN + PRE_LO - 1) / PRE_LO);
    localparam logic [S_W-1:0] FB_S = '0;

    logic [P_W-1:0] main_q, act_p_q, ld_p;
    logic [S_W-1:0] swal_q, act_s_q, ld_s;
    logic           last_w;

    // The period ends on the tick of the last main-counter step.
    assign last_w = tick_i && (main_q == P_W'(1));
    assign mod_o  = (swal_q != '0) ? psd_pkg::MOD_HI : psd_pkg::MOD_LO;

    // Pick the ratio for the next period: request, fallback, or the last accepted.
    always_comb begin
        if (req_ok_i) begin
            ld_p = req_p_i;
            ld_s = req_s_i;
        end else if (!rst_n) begin
            ld_p = FB_P;
            ld_s = FB_S;
        end else begin
            ld_p = act_p_q;
            ld_s = act_s_q;
        end
    end

    // Counter update: reload at reset or period end, else step on each tick.
    always_ff @(posedge clk_in) begin
        if (!rst_n || last_w) begin
            main_q  <= ld_p;
            swal_q  <= ld_s;
            act_p_q <= ld_p;
            act_s_q <= ld_s;
        end else if (tick_i) begin
            main_q <= main_q - P_W'(1);
            if (swal_q != '0) swal_q <= swal_q - S_W'(1);
        end
    end

    // Output pulse register: one cycle high after the period-end edge.
    always_ff @(posedge clk_in) begin
        if (!rst_n) pulse_o <= 1'b0;
        else        pulse_o <= last_w;
    end
endmodule

// File: rtl/pswallow_divider.sv
// Top of the pulse-swallow divider: prescaler, counters and legality check.
// Ratio N = PRE_LO*P + S. Assumes a synchronous, active-low reset held for
// at least one clock edge.
module pswallow_divider #(
    parameter int unsigned PRE_LO = psd_pkg::PRE_LO,
    parameter int unsigned P_W    = psd_pkg::P_W,
    parameter int unsigned S_W    = psd_pkg::S_W,
    parameter int unsigned N_MIN  = psd_pkg::N_MIN
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic [P_W-1:0] main_cnt_i,
    input  logic [S_W-1:0] swal_cnt_i,
    output logic           div_pulse_o,
    output logic           bad_ratio_o
);
    localparam int unsigned PH_W = $clog2(PRE_LO + 1);

    psd_pkg::modsel_e pre_mod;
    logic             pre_tick;
    logic             req_ok;

    psd_ratio_check #(.PRE_LO(PRE_LO), .P_W(P_W), .S_W(S_W), .N_MIN(N_MIN)) chk_u (
        .p_i  (main_cnt_i),
        .s_i  (swal_cnt_i),
        .ok_o (req_ok)
    );

    psd_prescaler #(.PRE_LO(PRE_LO), .PH_W(PH_W)) pre_u (
        .clk_in (clk_in),
        .rst_n  (rst_n),
        .mod_i  (pre_mod),
        .tick_o (pre_tick)
    );

    psd_counters #(.PRE_LO(PRE_LO), .P_W(P_W), .S_W(S_W), .N_MIN(N_MIN)) cnt_u (
        .clk_in   (clk_in),
        .rst_n    (rst_n),
        .tick_i   (pre_tick),
        .req_p_i  (main_cnt_i),
        .req_s_i  (swal_cnt_i),
        .req_ok_i (req_ok),
        .mod_o    (pre_mod),
        .pulse_o  (div_pulse_o)
    );

    // Registered illegal-setting flag that follows the inputs every cycle.
    always_ff @(posedge clk_in) begin
        bad_ratio_o <= !req_ok;
    end
endmodule

// File: rtl/psd_checker.sv
// Assertion checker for the pulse-swallow divider. It is attached to the
// top with bind. It tracks the pulse spacing with its own counter.
module psd_checker #(
    parameter int unsigned PRE_LO = psd_pkg::PRE_LO,
    parameter int unsigned P_W    = psd_pkg::P_W,
    parameter int unsigned S_W    = psd_pkg::S_W,
    parameter int unsigned N_MIN  = psd_pkg::N_MIN
) (
    input logic           clk_in,
    input logic           rst_n,
    input logic [P_W-1:0] main_cnt_i,
    input logic [S_W-1:0] swal_cnt_i,
    input logic           div_pulse_o,
    input logic           bad_ratio_o,
    input logic           mod,
    input logic           tick
);
    localparam int unsigned N_MAX = ((1 << P_W) - 1) * PRE_LO + PRE_LO - 1;
    localparam int unsigned GAP_W = $clog2(N_MAX + 2);

    logic [GAP_W-1:0] gap_q;
    logic             illegal_w;

    // Independent statement of an illegal request.
    assign illegal_w = (int'(main_cnt_i) <= int'(swal_cnt_i)) ||
                       (int'(main_cnt_i) * PRE_LO + int'(swal_cnt_i) < N_MIN);

    // Edge count since the last pulse or reset, saturating.
    always_ff @(posedge clk_in) begin
        if (!rst_n)                         gap_q <= '0;
        else if (div_pulse_o)               gap_q <= GAP_W'(1);
        else if (gap_q != {GAP_W{1'b1}})    gap_q <= gap_q + GAP_W'(1);
    end

    a_r1_gap_in_range: assert property (@(posedge clk_in) disable iff (!rst_n)
        div_pulse_o |-> (int'(gap_q) >= N_MIN && int'(gap_q) <= N_MAX));

    a_r2_single_cycle_pulse: assert property (@(posedge clk_in) disable iff (!rst_n)
        div_pulse_o |=> !div_pulse_o);

    a_r3_mod_fall_on_tick: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($past(rst_n) && $fell(mod)) |-> $past(tick));

    a_r3_mod_rise_on_tick: assert property (@(posedge clk_in) disable iff (!rst_n)
        ($past(rst_n) && $rose(mod)) |-> $past(tick));

    a_r4_flag_on_illegal: assert property (@(posedge clk_in) disable iff (!rst_n)
        illegal_w |=> bad_ratio_o);

    a_r4_flag_off_legal: assert property (@(posedge clk_in) disable iff (!rst_n)
        !illegal_w |=> !bad_ratio_o);
endmodule

bind pswallow_divider psd_checker #(
    .PRE_LO(PRE_LO), .P_W(P_W), .S_W(S_W), .N_MIN(N_MIN)
) psd_checker_i (
    .clk_in      (clk_in),
    .rst_n       (rst_n),
    .main_cnt_i  (main_cnt_i),
    .swal_cnt_i  (swal_cnt_i),
    .div_pulse_o (div_pulse_o),
    .bad_ratio_o (bad_ratio_o),
    .mod         (pre_mod),
    .tick        (pre_tick)
);

// File: tb/pswallow_divider_tb_top.sv
// Bench for the pulse-swallow divider: full sweep of legal settings, random
// retuning with legal and illegal values, and directed last-cycle changes.
module pswallow_divider_tb_top;
    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [4:0] p_in   = 5'd0;
    logic [1:0] s_in   = 2'd0;
    logic       pulse;
    logic       bad;

    int n_cmp = 0;
    int n_bad = 0;
    int cur_n = 0;

    always #2 clk_in = ~clk_in;

    pswallow_divider dut_i (
        .clk_in      (clk_in),
        .rst_n       (rst_n),
        .main_cnt_i  (p_in),
        .swal_cnt_i  (s_in),
        .div_pulse_o (pulse),
        .bad_ratio_o (bad)
    );

    function automatic bit legal(int p, int s);
        return (p > s) && (4 * p + s >= 16);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Runs one period, starting at the negedge where a pulse (or reset release) was seen.
    // When chg_at >= 0, the setting changes after chg_at edges of this period.
    task automatic run_period(input int chg_at, input int np, input int ns,
                              input int exp_len, input string req);
        int len = 0;
        if (chg_at == 0) begin p_in = 5'(np); s_in = 2'(ns); end
        while (1) begin
            @(posedge clk_in);
            len++;
            @(negedge clk_in);
            if (len == 1 && chg_at != -2) check(!pulse, "R2 pulse width", int'(pulse), 0);
            if (chg_at >= 0 && len == chg_at + 1)
                check(bad == !legal(np, ns), "R4 flag", int'(bad), int'(!legal(np, ns)));
            if (pulse) break;
            if (chg_at > 0 && len == chg_at) begin p_in = 5'(np); s_in = 2'(ns); end
            if (len > 300) break;
        end
        check(len == exp_len, req, len, exp_len);
    endtask

    task automatic do_reset(int p, int s);
        rst_n = 1'b0;
        p_in = 5'(p);
        s_in = 2'(s);
        repeat (3) @(posedge clk_in);
        @(negedge clk_in);
        check(!pulse, "R7 pulse low in reset", int'(pulse), 0);
        check(bad == !legal(p, s), "R4 flag in reset", int'(bad), int'(!legal(p, s)));
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R7: illegal setting during reset falls back to 16.
        do_reset(2, 1);
        run_period(-2, 0, 0, 16, "R7 first period fallback");
        cur_n = 16;

        // R7 R8: top of range straight out of reset.
        do_reset(31, 3);
        run_period(-2, 0, 0, 127, "R7 R8 first period 127");
        cur_n = 127;

        // R1 R3 R6 R8: every legal pair, changed at a random point of a period.
        for (int p = 4; p < 32; p++) begin
            for (int s = 0; s < 4; s++) begin
                int at = int'($urandom % 32'(cur_n));
                run_period(at, p, s, cur_n, "R6 old ratio completes");
                cur_n = 4 * p + s;
                run_period(-1, 0, 0, cur_n, "R1 R3 ratio 4P+S");
            end
        end

        // R6: change in the final input cycle of a period, both directions.
        run_period(cur_n - 1, 4, 0, cur_n, "R6 last-cycle change old");
        cur_n = 16;
        run_period(-1, 0, 0, 16, "R6 last-cycle change new R8");
        run_period(cur_n - 1, 9, 1, cur_n, "R6 last-cycle change old");
        cur_n = 37;
        run_period(-1, 0, 0, 37, "R6 last-cycle change new");

        // R5: illegal settings in the last cycle and mid-period keep the ratio.
        run_period(cur_n - 1, 3, 3, cur_n, "R5 R6 illegal at boundary");
        run_period(-1, 0, 0, cur_n, "R5 ratio kept");
        run_period(5, 2, 3, cur_n, "R5 illegal P<=S");
        run_period(-1, 0, 0, cur_n, "R5 ratio kept");

        // Random retuning with legal and illegal settings.
        for (int i = 0; i < 60; i++) begin
            int p  = int'($urandom % 32);
            int s  = int'($urandom % 4);
            int at = int'($urandom % 32'(cur_n));
            run_period(at, p, s, cur_n, "R6 random change");
            if (legal(p, s)) cur_n = 4 * p + s;
            run_period(-1, 0, 0, cur_n, legal(p, s) ? "R1 random ratio" : "R5 random illegal");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule